// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address that missed in a translation cache into a physical address. It splits the address into a 10-bit directory index, a 10-bit table index and a 12-bit page offset. It then fetches the directory entry and the table entry through a request/acknowledge memory port. At each level it checks the present bit and the access permissions. It marks entries as accessed and pages as written by writing the modified entry back to memory. The walk ends with either one translated address or one fault report.

A directory entry with the large-page bit set ends the walk at the first level and maps 4 MB. A caller that already holds the directory entry can supply it with the request. The walker then skips the directory read and starts from the supplied entry. The block takes one walk at a time. `busy` is high from the cycle after a request is accepted until the walker is back in idle.

States: `ST_IDLE`, `ST_READ_DIR`, `ST_READ_PTE`, `ST_UPDATE`, `ST_DONE`, `ST_FAULT`. The transitions are:

- IDLE→READ_DIR: a request arrives without a supplied directory entry.
- IDLE→READ_PTE, UPDATE, DONE or FAULT: a request arrives with a supplied directory entry. The walker judges that entry at once and picks the next state the same way it would after a directory read.
- READ_DIR→FAULT: the directory entry fails the checks.
- READ_DIR→UPDATE: the directory entry needs its accessed bit set.
- READ_DIR→READ_PTE: the directory entry passes and needs no update.
- READ_DIR→DONE: a large-page directory entry passes and needs no update.
- READ_PTE→FAULT: the table entry fails the checks.
- READ_PTE→UPDATE: the table entry needs its accessed or dirty bit set.
- READ_PTE→DONE: the table entry passes and needs no update.
- UPDATE→READ_PTE: the write-back of a directory entry is acknowledged.
- UPDATE→DONE: the write-back of a leaf entry is acknowledged.
- DONE→IDLE and FAULT→IDLE: always, after one cycle.

Top module: `pt_walker`

## Requirements
- R1: When a request is accepted without a supplied directory entry, the first memory access is a read at `dir_base + 4 * vaddr[31:22]`.
- R2: For a 4 KB walk, the table entry is read at `{dir_entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R3: When bit 0 (present) is clear in the directory entry or in the table entry, the walk ends in a fault with `fault_prot = 0`, and no further memory access is made.
- R4: Bit 1 of an entry grants write permission and bit 2 grants user access. A write to an entry with bit 1 clear, or a user access to an entry with bit 2 clear, at either level, ends in a fault with `fault_prot = 1`. Every fault reports the virtual address, the write flag and the user flag of the request. A supervisor read ignores both bits.
- R5: A passing 4 KB directory entry with bit 5 (accessed) clear is written back with bit 5 set, before the table entry is read.
- R6: A passing leaf entry is written back when bit 5 is clear, or when the access is a write and bit 6 (dirty) is clear. The written value is the entry with bit 5 set and, for a write, bit 6 set. A leaf entry that needs neither bit is not written.
- R7: A passing directory entry with bit 7 set is the leaf. The physical address is `{entry[31:22], vaddr[21:0]}`, `done_large` is 1, and no table entry is read.
- R8: A 4 KB walk finishes with `done_paddr = {leaf[31:12], vaddr[11:0]}`. In every successful walk, `done_entry` is the leaf entry as updated. `done_valid` and `fault_valid` each last one cycle and are never high together.
- R9: With `pde_hint_valid` high when the request is accepted, `pde_hint` is used as the directory entry and no directory read is made.
- R10: A request is accepted only while `busy` is low. `req_valid` while busy has no effect. `busy` is low in the cycle after `done_valid` or `fault_valid`.
- R11: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until the cycle in which `mem_ack` is high. Read data is taken from `mem_rdata` in that cycle.
- R12: After reset, `busy`, `mem_req`, `done_valid` and `fault_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only while idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| dir_base | input | 32 | Physical base address of the directory |
| pde_hint_valid | input | 1 | A cached directory entry is supplied |
| pde_hint | input | 32 | Cached directory entry |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory access address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done_valid | output | 1 | Translation finished (one cycle) |
| done_paddr | output | 32 | Translated physical address |
| done_entry | output | 32 | Leaf entry after update |
| done_large | output | 1 | Translation used a 4 MB page |
| fault_valid | output | 1 | Walk ended in a fault (one cycle) |
| fault_vaddr | output | 32 | Faulting virtual address |
| fault_prot | output | 1 | 1: permission fault, 0: not present |
| fault_write | output | 1 | Faulting access was a write |
| fault_user | output | 1 | Faulting access was from user mode |

## Verification
A wrong state or a wrong latched entry shows up at the memory port first. An extra, missing or misaddressed read or write-back appears in the very access where it happens, well before the walk's outcome. An error in the latched access type or in the saved entry shows up either as a wrong write-back value or in the single-cycle done or fault pulse. A walker that does not return to idle shows `busy` still high one cycle after the outcome. A walker that accepts a request while busy shows an access or an outcome that the model did not expect.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_READ_PTE,
        ST_UPDATE,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    // entry flag positions decoded by the walker
    localparam int BIT_PRESENT = 0;
    localparam int BIT_RW      = 1;
    localparam int BIT_US      = 2;
    localparam int BIT_ACC     = 5;
    localparam int BIT_DIRTY   = 6;
    localparam int BIT_LARGE   = 7;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int DIR_W = 10,
    parameter int TBL_W = 10,
    parameter int OFS_W = 12
) (
    input  logic [DIR_W+TBL_W+OFS_W-1:0] dir_base,
    input  logic [DIR_W-1:0]             dir_idx,
    input  logic [DIR_W+TBL_W-1:0]       table_base,
    input  logic [TBL_W+OFS_W-1:0]       va_low,
    input  logic [DIR_W+TBL_W-1:0]       leaf_frame,
    input  logic                         leaf_large,
    output logic [DIR_W+TBL_W+OFS_W-1:0] dir_addr,
    output logic [DIR_W+TBL_W+OFS_W-1:0] tbl_addr,
    output logic [DIR_W+TBL_W+OFS_W-1:0] paddr
);
    localparam int AW      = DIR_W + TBL_W + OFS_W;
    localparam int FRAME_W = DIR_W + TBL_W;
    localparam int LARGE_W = TBL_W + OFS_W;

    logic [AW-1:0] dir_step;
    logic [AW-1:0] tbl_step;

    // entries are four bytes wide, so the index is scaled by four
    assign dir_step = {{(AW-DIR_W-2){1'b0}}, dir_idx, 2'b00};
    assign tbl_step = {{(AW-TBL_W-2){1'b0}}, va_low[LARGE_W-1:OFS_W], 2'b00};

    assign dir_addr = dir_base + dir_step;
    assign tbl_addr = {table_base, {OFS_W{1'b0}}} + tbl_step;

    always_comb begin
        if (leaf_large) begin
            paddr = {leaf_frame[FRAME_W-1 -: DIR_W], va_low};
        end else begin
            paddr = {leaf_frame, va_low[OFS_W-1:0]};
        end
    end

endmodule

// File: rtl/pt_entry_judge.sv
module pt_entry_judge
    import pt_walker_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic [EW-1:0] entry,
    input  logic          at_dir,
    input  logic          acc_write,
    input  logic          acc_user,
    output logic          not_present,
    output logic          prot_fail,
    output logic          is_large,
    output logic          need_upd,
    output logic [EW-1:0] upd_entry
);
    logic leaf_level;

    // a large directory entry is itself the leaf
    assign leaf_level = !at_dir || entry[BIT_LARGE];

    always_comb begin
        not_present = !entry[BIT_PRESENT];
        prot_fail   = (acc_write && !entry[BIT_RW]) || (acc_user && !entry[BIT_US]);
        is_large    = at_dir && entry[BIT_LARGE];
        upd_entry   = entry;
        upd_entry[BIT_ACC] = 1'b1;
        if (leaf_level && acc_write) begin
            upd_entry[BIT_DIRTY] = 1'b1;
        end
        need_upd = (upd_entry != entry);
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int DIR_W = 10,
    parameter int TBL_W = 10,
    parameter int OFS_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic        req_write,
    input  logic        req_user,
    input  logic [31:0] dir_base,
    input  logic        pde_hint_valid,
    input  logic [31:0] pde_hint,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        done_valid,
    output logic [31:0] done_paddr,
    output logic [31:0] done_entry,
    output logic        done_large,
    output logic        fault_valid,
    output logic [31:0] fault_vaddr,
    output logic        fault_prot,
    output logic        fault_write,
    output logic        fault_user
);
    localparam int AW      = DIR_W + TBL_W + OFS_W;
    localparam int FRAME_W = DIR_W + TBL_W;
    localparam int LARGE_W = TBL_W + OFS_W;

    walk_state_t   state_q, state_d;
    logic [AW-1:0] va_q, va_d;
    logic          wr_q, wr_d;
    logic          usr_q, usr_d;
    logic [AW-1:0] dir_addr_q, dir_addr_d;
    logic [AW-1:0] upd_addr_q, upd_addr_d;
    logic [AW-1:0] entry_q, entry_d;
    logic          large_q, large_d;
    logic          upd_dir_q, upd_dir_d;
    logic          prot_q, prot_d;

    // judge inputs: the supplied entry while idle, memory data otherwise
    logic [AW-1:0] j_entry;
    logic          j_at_dir, j_write, j_user;
    logic          j_np, j_prot, j_large, j_need;
    logic [AW-1:0] j_upd;

    logic [AW-1:0] dir_addr_c, tbl_addr_c, paddr_c, cur_dir_addr;
    logic          take_dir, take_leaf;

    assign j_entry  = (state_q == ST_IDLE) ? pde_hint : mem_rdata;
    assign j_at_dir = (state_q == ST_IDLE) || (state_q == ST_READ_DIR);
    assign j_write  = (state_q == ST_IDLE) ? req_write : wr_q;
    assign j_user   = (state_q == ST_IDLE) ? req_user : usr_q;
    assign cur_dir_addr = (state_q == ST_IDLE) ? dir_addr_c : dir_addr_q;

    pt_entry_judge #(.EW(AW)) u_judge (
        .entry       (j_entry),
        .at_dir      (j_at_dir),
        .acc_write   (j_write),
        .acc_user    (j_user),
        .not_present (j_np),
        .prot_fail   (j_prot),
        .is_large    (j_large),
        .need_upd    (j_need),
        .upd_entry   (j_upd)
    );

    pt_addr_gen #(.DIR_W(DIR_W), .TBL_W(TBL_W), .OFS_W(OFS_W)) u_addr (
        .dir_base   (dir_base),
        .dir_idx    (req_vaddr[AW-1 -: DIR_W]),
        .table_base (entry_q[AW-1 -: FRAME_W]),
        .va_low     (va_q[LARGE_W-1:0]),
        .leaf_frame (entry_q[AW-1 -: FRAME_W]),
        .leaf_large (large_q),
        .dir_addr   (dir_addr_c),
        .tbl_addr   (tbl_addr_c),
        .paddr      (paddr_c)
    );

    // next-state and data path
    always_comb begin
        state_d    = state_q;
        va_d       = va_q;
        wr_d       = wr_q;
        usr_d      = usr_q;
        dir_addr_d = dir_addr_q;
        upd_addr_d = upd_addr_q;
        entry_d    = entry_q;
        large_d    = large_q;
        upd_dir_d  = upd_dir_q;
        prot_d     = prot_q;
        take_dir   = 1'b0;
        take_leaf  = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    va_d       = req_vaddr;
                    wr_d       = req_write;
                    usr_d      = req_user;
                    dir_addr_d = dir_addr_c;
                    large_d    = 1'b0;
                    if (pde_hint_valid) begin
                        take_dir = 1'b1;
                    end else begin
                        state_d = ST_READ_DIR;
                    end
                end
            end
            ST_READ_DIR: take_dir  = mem_ack;
            ST_READ_PTE: take_leaf = mem_ack;
            ST_UPDATE: begin
                if (mem_ack) begin
                    state_d = upd_dir_q ? ST_READ_PTE : ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase

        if (take_dir || take_leaf) begin
            if (j_np) begin
                prot_d  = 1'b0;
                state_d = ST_FAULT;
            end else if (j_prot) begin
                prot_d  = 1'b1;
                state_d = ST_FAULT;
            end else begin
                entry_d = j_upd;
                if (take_leaf || j_large) begin
                    large_d    = take_dir;
                    upd_addr_d = take_dir ? cur_dir_addr : tbl_addr_c;
                    upd_dir_d  = 1'b0;
                    state_d    = j_need ? ST_UPDATE : ST_DONE;
                end else begin
                    upd_addr_d = cur_dir_addr;
                    upd_dir_d  = 1'b1;
                    state_d    = j_need ? ST_UPDATE : ST_READ_PTE;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            va_q       <= '0;
            wr_q       <= 1'b0;
            usr_q      <= 1'b0;
            dir_addr_q <= '0;
            upd_addr_q <= '0;
            entry_q    <= '0;
            large_q    <= 1'b0;
            upd_dir_q  <= 1'b0;
            prot_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            va_q       <= va_d;
            wr_q       <= wr_d;
            usr_q      <= usr_d;
            dir_addr_q <= dir_addr_d;
            upd_addr_q <= upd_addr_d;
            entry_q    <= entry_d;
            large_q    <= large_d;
            upd_dir_q  <= upd_dir_d;
            prot_q     <= prot_d;
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        busy        = 1'b1;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        done_valid  = 1'b0;
        fault_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_READ_DIR: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr_q;
            end
            ST_READ_PTE: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr_c;
            end
            ST_UPDATE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = upd_addr_q;
                mem_wdata = entry_q;
            end
            ST_DONE:  done_valid  = 1'b1;
            ST_FAULT: fault_valid = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    assign done_paddr  = paddr_c;
    assign done_entry  = entry_q;
    assign done_large  = large_q;
    assign fault_vaddr = va_q;
    assign fault_prot  = prot_q;
    assign fault_write = wr_q;
    assign fault_user  = usr_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import pt_walker_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        done_valid,
    input logic        fault_valid
);

    assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || fault_valid) |=> !busy);

    assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));

    assert_writeback_accessed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[BIT_ACC]);

    assert_quiet_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || fault_valid) |-> !mem_req);

endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .done_valid  (done_valid),
    .fault_valid (fault_valid)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] dir_base = 32'h0001_0000;
    logic        pde_hint_valid = 1'b0;
    logic [31:0] pde_hint = '0;
    logic        busy, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done_valid, done_large, fault_valid, fault_prot, fault_write, fault_user;
    logic [31:0] done_paddr, done_entry, fault_vaddr;

    always #2 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
        .dir_base(dir_base), .pde_hint_valid(pde_hint_valid), .pde_hint(pde_hint),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done_valid(done_valid), .done_paddr(done_paddr), .done_entry(done_entry), .done_large(done_large),
        .fault_valid(fault_valid), .fault_vaddr(fault_vaddr), .fault_prot(fault_prot),
        .fault_write(fault_write), .fault_user(fault_user)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } acc_t;

    logic [31:0] mem [logic [31:0]];
    acc_t        exp_q[$];
    string       exp_tag[$];
    int          n_checks = 0;
    int          n_fail = 0;
    int          lat = 0;
    int          wait_cnt = 0;
    bit          exp_active = 0;
    bit          got_result = 0;
    bit          exp_fault;
    logic [31:0] exp_paddr, exp_entry, exp_va;
    logic        exp_large, exp_prot, exp_wr, exp_usr;
    string       res_tag;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [64:0] act, input logic [64:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // behavioural reference: expected accesses and outcome from memory contents
    task automatic predict(input logic [31:0] va, input bit wr, input bit us,
                           input bit hv, input logic [31:0] hint);
        logic [31:0] daddr, pde, taddr, leaf, laddr, nleaf;
        bit lg;
        exp_q.delete();
        exp_tag.delete();
        exp_va = va; exp_wr = wr; exp_usr = us;
        daddr = dir_base + {20'h0, va[31:22], 2'b00};
        if (hv) begin
            pde = hint;
        end else begin
            exp_q.push_back('{1'b0, daddr, 32'h0}); exp_tag.push_back("R1");
            pde = rd(daddr);
        end
        if (!pde[0]) begin
            exp_fault = 1; exp_prot = 0; res_tag = "R3"; return;
        end
        if ((wr && !pde[1]) || (us && !pde[2])) begin
            exp_fault = 1; exp_prot = 1; res_tag = "R4"; return;
        end
        if (pde[7]) begin
            leaf = pde; laddr = daddr; lg = 1;
        end else begin
            lg = 0;
            if (!pde[5]) begin
                pde = pde | 32'h20;
                exp_q.push_back('{1'b1, daddr, pde}); exp_tag.push_back("R5");
            end
            taddr = {pde[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
            exp_q.push_back('{1'b0, taddr, 32'h0}); exp_tag.push_back("R2");
            leaf = rd(taddr); laddr = taddr;
            if (!leaf[0]) begin
                exp_fault = 1; exp_prot = 0; res_tag = "R3"; return;
            end
            if ((wr && !leaf[1]) || (us && !leaf[2])) begin
                exp_fault = 1; exp_prot = 1; res_tag = "R4"; return;
            end
        end
        nleaf = leaf | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (nleaf != leaf) begin
            exp_q.push_back('{1'b1, laddr, nleaf}); exp_tag.push_back("R6");
        end
        exp_fault = 0;
        exp_large = lg;
        exp_entry = nleaf;
        exp_paddr = lg ? {leaf[31:22], va[21:0]} : {leaf[31:12], va[11:0]};
        res_tag   = lg ? "R7" : "R8";
    endtask

    // memory responder and per-clock comparison with the model
    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (rst_n) begin
            if (mem_req) begin
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    mem_ack = 1'b1;
                    if (exp_q.size() == 0) begin
                        check(0, "R3", "unexpected access", {mem_we, mem_addr, mem_wdata}, 65'h0);
                    end else begin
                        acc_t e;
                        string t;
                        e = exp_q.pop_front();
                        t = exp_tag.pop_front();
                        check(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
                              t, "memory access", {mem_we, mem_addr, e.we ? mem_wdata : 32'h0},
                              {e.we, e.addr, e.data});
                    end
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    else        mem_rdata = rd(mem_addr);
                end else begin
                    wait_cnt++;
                end
            end
            if (done_valid || fault_valid) begin
                if (!exp_active) begin
                    check(0, "R10", "unexpected outcome", {63'h0, done_valid, fault_valid}, 65'h0);
                end else begin
                    exp_active = 0;
                    got_result = 1;
                    check(fault_valid == exp_fault && done_valid == !exp_fault, res_tag, "outcome kind",
                          {63'h0, done_valid, fault_valid}, {63'h0, !exp_fault, exp_fault});
                    if (exp_fault) begin
                        check({fault_vaddr, fault_prot, fault_write, fault_user} ==
                              {exp_va, exp_prot, exp_wr, exp_usr}, res_tag, "fault report",
                              {30'h0, fault_vaddr, fault_prot, fault_write, fault_user},
                              {30'h0, exp_va, exp_prot, exp_wr, exp_usr});
                    end else begin
                        check({done_paddr, done_entry, done_large} == {exp_paddr, exp_entry, exp_large},
                              res_tag, "translation", {done_paddr, done_entry, done_large},
                              {exp_paddr, exp_entry, exp_large});
                    end
                end
            end
        end
    end

    task automatic walk(input logic [31:0] va, input bit wr, input bit us,
                        input bit hv, input logic [31:0] hint, input int latency, input bit poke);
        int n;
        lat = latency;
        wait_cnt = 0;
        predict(va, wr, us, hv, hint);
        got_result = 0;
        exp_active = 1;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = us;
        pde_hint_valid = hv; pde_hint = hint;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        pde_hint_valid = 1'b0;
        if (poke) begin
            // R10: a second request while busy must not disturb the walk
            req_vaddr = 32'h0080_0000; req_write = 1'b1; req_user = 1'b1;
            req_valid = 1'b1;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!got_result && n < 300) begin
            @(posedge clk);
            n++;
        end
        if (!got_result) begin
            check(0, "R10", "walk timeout", 65'(n), 65'd300);
            exp_active = 0;
        end
        @(negedge clk);
        check(busy == 1'b0, "R10", "busy after outcome", {64'h0, busy}, 65'h0);
        check(exp_q.size() == 0, res_tag, "missing accesses", 65'(exp_q.size()), 65'h0);
    endtask

    initial begin
        mem[32'h0001_0004] = 32'h0002_0007;
        mem[32'h0002_000C] = 32'h0005_5007;
        mem[32'h0002_0014] = 32'h0006_6005;
        mem[32'h0001_000C] = 32'h0003_0023;
        mem[32'h0003_0004] = 32'h0007_7003;
        mem[32'h0003_000C] = 32'h0008_8027;
        mem[32'h0001_0010] = 32'h1240_0087;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check({busy, mem_req, done_valid, fault_valid} == 4'h0, "R12", "reset outputs",
              {61'h0, busy, mem_req, done_valid, fault_valid}, 65'h0);

        walk(32'h0040_3ABC, 0, 1, 0, 32'h0, 0, 0); // R5 R6 R8 first touch
        walk(32'h0040_3ABC, 0, 1, 0, 32'h0, 2, 0); // R6 no write-back needed
        walk(32'h0040_3ABC, 1, 1, 0, 32'h0, 1, 0); // R6 dirty on write
        walk(32'h0080_0000, 0, 0, 0, 32'h0, 1, 0); // R3 directory not present
        walk(32'h0040_4000, 0, 0, 0, 32'h0, 0, 0); // R3 table not present
        walk(32'h0040_5010, 1, 1, 0, 32'h0, 0, 0); // R4 write to read-only
        walk(32'h00C0_1000, 0, 1, 0, 32'h0, 0, 0); // R4 user on supervisor directory
        walk(32'h00C0_1000, 0, 0, 0, 32'h0, 1, 0); // R4 supervisor passes
        walk(32'h0112_3456, 1, 1, 0, 32'h0, 0, 0); // R7 large page
        walk(32'h0040_3ABC, 0, 0, 1, 32'h0003_0027, 0, 0); // R9 supplied entry
        walk(32'h0040_3ABC, 1, 0, 1, 32'h0800_00E7, 0, 0); // R9 R7 no access at all
        walk(32'h0040_3ABC, 0, 0, 1, 32'h0002_0026, 0, 0); // R9 R3 supplied not present
        walk(32'h0040_3ABC, 0, 1, 0, 32'h0, 3, 1); // R10 R11 request while busy

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule